// File: doc/BRIEF.md
# Segmented Logical to Linear Address Translator

This block converts a logical address, made of a segment register number and a 32-bit offset, into a 32-bit linear address. It never reads memory. A small register file inside the block holds the cached descriptor state for six segment registers. Each entry has a valid bit, a 32-bit base, a 32-bit limit, a code/data flag and a single permission bit. Software loads these entries through a write port whenever a segment register is reloaded.

Each request also carries an access kind (read, write or execute) and an access size of one to four bytes. The block checks the request against the selected entry. It tests the entry's valid bit, checks that the access kind is allowed for the segment type, and checks that the last byte of the access is within the limit. One cycle after the request it returns a strobe, a 2-bit fault code and, when no fault is found, the base plus the offset, wrapped modulo 2^32.

Top module: `seg_xlate`

## Requirements
- R1: Each cycle with `req_valid` high gives exactly one cycle of `rsp_valid` high on the next clock edge. A cycle without a request gives `rsp_valid` low on the next edge. After reset, `rsp_valid`, `rsp_fault` and `rsp_linear` are all zero.
- R2: When no fault is found, `rsp_linear` equals the entry base plus `req_offset`, wrapped modulo 2^32.
- R3: Fault code 1 (limit) is reported when `req_offset + req_size_m1` is greater than the entry limit. The sum is computed with 33 bits, so an access that runs past the limit or past FFFFFFFFh faults.
- R4: Fault code 2 (type) is reported in these cases. Access kinds are encoded as read=0, write=1, execute=2 and reserved=3.
  - a write to a code segment
  - a write to a data segment whose permission bit is 0 (read-only)
  - a read from a code segment whose permission bit is 0 (execute-only)
  - an execute from a data segment
  - any request with kind 3
- R5: Fault code 3 (invalid) is reported when the selected entry's valid bit is clear, or when `req_seg` is 6 or above. Reset clears every valid bit.
- R6: When more than one fault applies, invalid takes priority over type, and type takes priority over limit. A faulting response drives `rsp_linear` to zero. Fault code 0 means no fault.
- R7: When `cfg_we` is high, entry `cfg_idx` is loaded from the `cfg_*` fields at the clock edge. In the `cfg_*` fields, `cfg_code`=1 marks a code segment. `cfg_rw` means writable for a data segment and readable for a code segment. A request in the same cycle as a write sees the entry as it was before the write. A write with `cfg_idx` of 6 or above changes no entry.
- R8: A valid, writable data entry with base 0 and limit FFFFFFFFh returns every offset unchanged for a single-byte read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one cache entry |
| cfg_idx | input | 3 | Entry to load |
| cfg_vld | input | 1 | Valid bit to store |
| cfg_code | input | 1 | 1 = code segment, 0 = data segment |
| cfg_rw | input | 1 | Data: writable; code: readable |
| cfg_base | input | 32 | Segment base |
| cfg_limit | input | 32 | Highest legal offset |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Segment register number |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_size_m1 | input | 2 | Access size in bytes minus one |
| req_offset | input | 32 | Offset within segment |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 type, 3 invalid |
| rsp_linear | output | 32 | Linear address, zero on fault |

## Verification
The bench tests the limit at the exact last legal byte and one byte past it, for both one-byte and four-byte accesses. It also tests an access that straddles FFFFFFFFh in a flat segment. A design that dropped the access size or compared with only 32 bits would let these accesses through or wrap into a pass.

Every type rule is exercised, along with a request that breaks both the type rule and the limit, and a request to an invalid entry with a forbidden kind. A wrong fault priority would report the wrong code for those requests. The bench also writes an entry in the same cycle it translates through that entry, and writes to out-of-range indices. A design that bypassed the new value or aliased the index would change a result it must not.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_LIMIT   = 2'd1,
    FLT_TYPE    = 2'd2,
    FLT_INVALID = 2'd3
  } fault_e;

endpackage

// File: rtl/seg_cache.sv
module seg_cache #(
  parameter int AW      = 32,
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic             wr_code,
  input  logic             wr_rw,
  input  logic [AW-1:0]    wr_base,
  input  logic [AW-1:0]    wr_limit,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic             rd_code,
  output logic             rd_rw,
  output logic [AW-1:0]    rd_base,
  output logic [AW-1:0]    rd_limit
);

  logic [NUM_SEG-1:0] vld_v;
  logic [NUM_SEG-1:0] code_v;
  logic [NUM_SEG-1:0] rw_v;
  logic [AW-1:0]      base_v  [NUM_SEG];
  logic [AW-1:0]      limit_v [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic          sel;
    logic          vld_r;
    logic          code_r;
    logic          rw_r;
    logic [AW-1:0] base_r;
    logic [AW-1:0] limit_r;

    assign sel = wr_en && (wr_idx == SEG_W'(g));

    // valid bit carries reset; payload is enable-only storage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
      end else if (sel) begin
        vld_r <= wr_vld;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        code_r  <= wr_code;
        rw_r    <= wr_rw;
        base_r  <= wr_base;
        limit_r <= wr_limit;
      end
    end

    assign vld_v[g]   = vld_r;
    assign code_v[g]  = code_r;
    assign rw_v[g]    = rw_r;
    assign base_v[g]  = base_r;
    assign limit_v[g] = limit_r;
  end

  always_comb begin
    rd_vld   = 1'b0;
    rd_code  = 1'b0;
    rd_rw    = 1'b0;
    rd_base  = '0;
    rd_limit = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_idx == SEG_W'(i)) begin
        rd_vld   = vld_v[i];
        rd_code  = code_v[i];
        rd_rw    = rw_v[i];
        rd_base  = base_v[i];
        rd_limit = limit_v[i];
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 2
) (
  input  logic              ent_vld,
  input  logic              ent_code,
  input  logic              ent_rw,
  input  logic [AW-1:0]     ent_base,
  input  logic [AW-1:0]     ent_limit,
  input  logic [1:0]        kind,
  input  logic [SIZE_W-1:0] size_m1,
  input  logic [AW-1:0]     offset,
  output logic [1:0]        fault,
  output logic [AW-1:0]     linear
);

  localparam int EW = AW + 1;

  logic          type_bad;
  logic          over_limit;
  logic [EW-1:0] last_byte;

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_READ:  type_bad = ent_code & ~ent_rw;
      ACC_WRITE: type_bad = ent_code | ~ent_rw;
      ACC_EXEC:  type_bad = ~ent_code;
      default:   type_bad = 1'b1;
    endcase
  end

  // extra carry bit keeps the end-of-space straddle visible
  assign last_byte  = {1'b0, offset} + EW'(size_m1);
  assign over_limit = last_byte > {1'b0, ent_limit};

  always_comb begin
    fault  = FLT_NONE;
    linear = '0;
    if (!ent_vld) begin
      fault = FLT_INVALID;
    end else if (type_bad) begin
      fault = FLT_TYPE;
    end else if (over_limit) begin
      fault = FLT_LIMIT;
    end else begin
      linear = ent_base + offset;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 6,
  parameter int SIZE_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_SEG)-1:0] cfg_idx,
  input  logic                       cfg_vld,
  input  logic                       cfg_code,
  input  logic                       cfg_rw,
  input  logic [ADDR_W-1:0]          cfg_base,
  input  logic [ADDR_W-1:0]          cfg_limit,
  input  logic                       req_valid,
  input  logic [$clog2(NUM_SEG)-1:0] req_seg,
  input  logic [1:0]                 req_kind,
  input  logic [SIZE_W-1:0]          req_size_m1,
  input  logic [ADDR_W-1:0]          req_offset,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_fault,
  output logic [ADDR_W-1:0]          rsp_linear
);

  localparam int SEG_W = $clog2(NUM_SEG);

  logic              e_vld, e_code, e_rw;
  logic [ADDR_W-1:0] e_base, e_limit;
  logic [1:0]        chk_fault;
  logic [ADDR_W-1:0] chk_linear;

  logic              vld_d,  vld_q;
  logic [1:0]        flt_d,  flt_q;
  logic [ADDR_W-1:0] lin_d,  lin_q;

  seg_cache #(
    .AW(ADDR_W), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W)
  ) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_vld   (cfg_vld),
    .wr_code  (cfg_code),
    .wr_rw    (cfg_rw),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .rd_idx   (req_seg),
    .rd_vld   (e_vld),
    .rd_code  (e_code),
    .rd_rw    (e_rw),
    .rd_base  (e_base),
    .rd_limit (e_limit)
  );

  seg_check #(
    .AW(ADDR_W), .SIZE_W(SIZE_W)
  ) u_check (
    .ent_vld   (e_vld),
    .ent_code  (e_code),
    .ent_rw    (e_rw),
    .ent_base  (e_base),
    .ent_limit (e_limit),
    .kind      (req_kind),
    .size_m1   (req_size_m1),
    .offset    (req_offset),
    .fault     (chk_fault),
    .linear    (chk_linear)
  );

  // next-state: load on request, hold otherwise
  always_comb begin
    vld_d = req_valid;
    flt_d = flt_q;
    lin_d = lin_q;
    if (req_valid) begin
      flt_d = chk_fault;
      lin_d = chk_linear;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      flt_q <= FLT_NONE;
      lin_q <= '0;
    end else begin
      vld_q <= vld_d;
      flt_q <= flt_d;
      lin_q <= lin_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_fault  = flt_q;
  assign rsp_linear = lin_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 6,
  parameter int SIZE_W  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [$clog2(NUM_SEG)-1:0] cfg_idx,
  input logic                       cfg_vld,
  input logic                       cfg_code,
  input logic [ADDR_W-1:0]          cfg_base,
  input logic                       req_valid,
  input logic [$clog2(NUM_SEG)-1:0] req_seg,
  input logic [1:0]                 req_kind,
  input logic [ADDR_W-1:0]          req_offset,
  input logic                       rsp_valid,
  input logic [1:0]                 rsp_fault,
  input logic [ADDR_W-1:0]          rsp_linear
);

  localparam int SEG_W = $clog2(NUM_SEG);

  logic [NUM_SEG-1:0] sh_vld;
  logic [NUM_SEG-1:0] sh_code;
  logic [ADDR_W-1:0]  sh_base [NUM_SEG];
  logic [ADDR_W-1:0]  exp_lin;
  logic               in_rng;
  logic               sel_vld;
  logic               sel_code;
  logic [ADDR_W-1:0]  sel_base;

  always_comb begin
    in_rng   = 1'b0;
    sel_vld  = 1'b0;
    sel_code = 1'b0;
    sel_base = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (req_seg == SEG_W'(i)) begin
        in_rng   = 1'b1;
        sel_vld  = sh_vld[i];
        sel_code = sh_code[i];
        sel_base = sh_base[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_vld  <= '0;
      sh_code <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (cfg_idx == SEG_W'(i)) begin
          sh_vld[i]  <= cfg_vld;
          sh_code[i] <= cfg_code;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (cfg_idx == SEG_W'(i)) sh_base[i] <= cfg_base;
      end
    end
    if (req_valid) exp_lin <= sel_base + req_offset;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_LINEAR_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_linear == exp_lin); // R2
  AST_WRITE_CODE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_rng && sel_vld && sel_code && req_kind == 2'd1) |=> rsp_fault == 2'd2); // R4
  AST_INVALID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(in_rng && sel_vld)) |=> rsp_fault == 2'd3); // R5
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_linear == '0); // R6

endmodule

bind seg_xlate seg_xlate_chk #(
  .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SIZE_W(SIZE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_vld    (cfg_vld),
  .cfg_code   (cfg_code),
  .cfg_base   (cfg_base),
  .req_valid  (req_valid),
  .req_seg    (req_seg),
  .req_kind   (req_kind),
  .req_offset (req_offset),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_linear (rsp_linear)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_vld = 1'b0;
  logic        cfg_code = 1'b0;
  logic        cfg_rw = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [31:0] cfg_limit = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size_m1 = '0;
  logic [31:0] req_offset = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_linear;

  always #10 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_vld(cfg_vld), .cfg_code(cfg_code), .cfg_rw(cfg_rw),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .req_valid(req_valid),
    .req_seg(req_seg), .req_kind(req_kind), .req_size_m1(req_size_m1),
    .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_linear(rsp_linear)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench's own copy of the descriptor cache
  bit          m_vld   [8];
  bit          m_code  [8];
  bit          m_rw    [8];
  logic [31:0] m_base  [8];
  logic [31:0] m_limit [8];

  // scoreboard queues
  logic [1:0]  q_flt [$];
  logic [31:0] q_lin [$];
  string       q_tag [$];

  function automatic logic [33:0] model(int seg, int kind, int sz, logic [31:0] off);
    bit bad_type;
    logic [32:0] last;
    if (seg > 5 || !m_vld[seg]) return {2'd3, 32'd0};
    case (kind)
      0: bad_type = m_code[seg] && !m_rw[seg];
      1: bad_type = m_code[seg] || !m_rw[seg];
      2: bad_type = !m_code[seg];
      default: bad_type = 1'b1;
    endcase
    if (bad_type) return {2'd2, 32'd0};
    last = {1'b0, off} + 33'(sz);
    if (last > {1'b0, m_limit[seg]}) return {2'd1, 32'd0};
    return {2'd0, m_base[seg] + off};
  endfunction

  task automatic check(bit ok, string tag, logic [33:0] act, logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual fault=%0d lin=%h expected fault=%0d lin=%h",
               tag, act[33:32], act[31:0], exp[33:32], exp[31:0]);
    end
  endtask

  task automatic push_exp(int seg, int kind, int sz, logic [31:0] off, string tag);
    logic [33:0] e;
    e = model(seg, kind, sz, off);
    q_flt.push_back(e[33:32]);
    q_lin.push_back(e[31:0]);
    q_tag.push_back(tag);
  endtask

  task automatic drive_req(int seg, int kind, int sz, logic [31:0] off);
    req_valid   = 1'b1;
    req_seg     = 3'(seg);
    req_kind    = 2'(kind);
    req_size_m1 = 2'(sz);
    req_offset  = off;
  endtask

  task automatic drive_cfg(int idx, bit v, bit code, bit rw, logic [31:0] b, logic [31:0] l);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_vld = v; cfg_code = code;
    cfg_rw = rw; cfg_base = b; cfg_limit = l;
  endtask

  task automatic model_cfg(int idx, bit v, bit code, bit rw, logic [31:0] b, logic [31:0] l);
    if (idx <= 5) begin
      m_vld[idx] = v; m_code[idx] = code; m_rw[idx] = rw;
      m_base[idx] = b; m_limit[idx] = l;
    end
  endtask

  // one request cycle; called at a falling edge
  task automatic xact(int seg, int kind, int sz, logic [31:0] off, string tag);
    drive_req(seg, kind, sz, off);
    push_exp(seg, kind, sz, off, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(int idx, bit v, bit code, bit rw, logic [31:0] b, logic [31:0] l);
    drive_cfg(idx, v, code, rw, b, l);
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg(idx, v, code, rw, b, l);
  endtask

  // R7: write and translate through the same entry in one cycle
  task automatic load_and_xact(int idx, bit v, bit code, bit rw, logic [31:0] b,
                               logic [31:0] l, int kind, logic [31:0] off, string tag);
    drive_cfg(idx, v, code, rw, b, l);
    drive_req(idx, kind, 0, off);
    push_exp(idx, kind, 0, off, tag);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
    model_cfg(idx, v, code, rw, b, l);
  endtask

  // monitor: pops one expected item per response strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (q_flt.size() == 0) begin
          check(1'b0, "R1 unexpected response", {rsp_fault, rsp_linear}, 34'd0);
        end else begin
          logic [1:0]  ef;
          logic [31:0] el;
          string       tg;
          ef = q_flt.pop_front();
          el = q_lin.pop_front();
          tg = q_tag.pop_front();
          check(rsp_fault == ef && rsp_linear == el, tg,
                {rsp_fault, rsp_linear}, {ef, el});
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 1'b0; m_code[i] = 1'b0; m_rw[i] = 1'b0;
      m_base[i] = '0; m_limit[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_fault == 2'd0 && rsp_linear == 32'd0,
          "R1 reset state", {rsp_fault, rsp_linear}, 34'd0);

    // R5: nothing loaded yet
    xact(0, 0, 0, 32'h10, "R5 entry invalid after reset");

    // R8 flat segment
    load(0, 1, 0, 1, 32'h0, 32'hFFFF_FFFF);
    xact(0, 0, 0, 32'h0000_0000, "R8 flat offset 0");
    xact(0, 1, 0, 32'h1234_5678, "R8 flat write mid");
    xact(0, 0, 0, 32'hFFFF_FFFF, "R8 flat top byte");
    xact(0, 0, 1, 32'hFFFF_FFFE, "R3 flat two bytes end exactly");
    xact(0, 0, 1, 32'hFFFF_FFFF, "R3 flat straddle past top");
    xact(0, 1, 3, 32'hFFFF_FFFD, "R3 flat four bytes past top");

    // R2 wraparound base addition
    load(1, 1, 0, 1, 32'hF000_0000, 32'hFFFF_FFFF);
    xact(1, 0, 0, 32'h2000_0000, "R2 base add wraps");
    xact(1, 1, 3, 32'h0000_0100, "R2 base plus small offset");

    // R3 small limit
    load(2, 1, 0, 1, 32'h0000_1000, 32'h0000_00FF);
    xact(2, 0, 0, 32'h0000_00FF, "R3 last legal byte");
    xact(2, 0, 0, 32'h0000_0100, "R3 one byte past limit");
    xact(2, 0, 3, 32'h0000_00FC, "R3 four bytes ending at limit");
    xact(2, 1, 3, 32'h0000_00FE, "R3 four bytes crossing limit");

    // R4 type rules
    load(3, 1, 0, 0, 32'h0002_0000, 32'h0000_FFFF);
    load(4, 1, 1, 0, 32'h0004_0000, 32'h0000_FFFF);
    load(5, 1, 1, 1, 32'h0008_0000, 32'h0000_FFFF);
    xact(3, 0, 0, 32'h10, "R4 read of read-only data");
    xact(3, 1, 0, 32'h10, "R4 write to read-only data");
    xact(3, 2, 0, 32'h10, "R4 execute from data");
    xact(4, 2, 0, 32'h20, "R4 execute from execute-only code");
    xact(4, 0, 0, 32'h20, "R4 read from execute-only code");
    xact(5, 0, 0, 32'h30, "R4 read from readable code");
    xact(5, 1, 0, 32'h30, "R4 write to code");
    xact(0, 3, 0, 32'h40, "R4 reserved kind");

    // R6 priority
    xact(3, 1, 0, 32'h0001_0000, "R6 type beats limit");
    xact(2, 0, 0, 32'h0000_0200, "R6 limit fault zero address");
    load(4, 0, 1, 0, 32'h0004_0000, 32'h0000_FFFF);
    xact(4, 1, 0, 32'h20, "R6 invalid beats type");

    // R5 index beyond table
    xact(6, 0, 0, 32'h0, "R5 segment index 6");
    xact(7, 2, 0, 32'h0, "R5 segment index 7");

    // R7 out-of-range writes change nothing
    load(6, 1, 0, 1, 32'hAAAA_0000, 32'hFFFF_FFFF);
    load(7, 1, 0, 0, 32'h5555_0000, 32'h0);
    xact(6, 0, 0, 32'h0, "R7 index 6 still invalid");
    xact(0, 1, 0, 32'h0000_0044, "R7 entry 0 untouched");
    xact(2, 0, 0, 32'h0000_0080, "R7 entry 2 untouched");

    // R7 same-cycle write sees old contents
    load_and_xact(2, 1, 0, 1, 32'h0700_0000, 32'hFFFF_FFFF, 0, 32'h0000_0400,
                  "R7 same-cycle old limit");
    xact(2, 0, 0, 32'h0000_0400, "R7 new entry after write");
    load_and_xact(1, 0, 0, 1, 32'h0, 32'h0, 0, 32'h0000_0001,
                  "R7 same-cycle old valid");
    xact(1, 0, 0, 32'h0000_0001, "R5 cleared valid bit");

    // R1 idle gap: no strobe without a request
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 idle gives no strobe", {1'b0, rsp_valid, 32'd0}, 34'd0);

    repeat (3) @(negedge clk);
    check(q_flt.size() == 0, "R1 every request answered",
          34'(q_flt.size()), 34'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule